// File: doc/BRIEF.md
# Interrupt presentation controller

This block is the per-processor end of a two-level interrupt controller. It serves one processor. A source layer offers it interrupts, each with a source number and a priority. The block keeps at most one pending interrupt. It accepts or bounces each offer and drives a single interrupt line to the processor. A numerically smaller priority is more favoured. An offer that cannot be held is sent straight back to the source layer, which may offer it again later. The block does not queue it.

Software on the processor works the block through four register operations. Accept reads and acknowledges the pending interrupt. Set-current-priority changes the processor's masking level. Set-IPI-priority requests an inter-processor interrupt. End-of-interrupt closes handling and restores a priority. An internal inter-processor interrupt with fixed source number 2 competes with external offers through its own priority register.

Towards the source layer, the block issues one-cycle strobes: reject (with a source number), end-of-interrupt (with a source number) and resend. The source layer uses these to re-offer interrupts it is still holding.

Top module: `irq_pres_ctrl`

## Requirements
- R1: After reset the line is low, no strobe is active, the 32-bit state word reads zero and the IPI priority register holds 0xff, so raising the current priority to 0xff presents no IPI.
- R2: An offer is bounced on `off_rej_*` (with its source number, the cycle after it is offered) when its priority is numerically greater than or equal to the current priority, or when a pending interrupt already has a priority less than or equal to it; an offer with source number 0 is ignored entirely.
- R3: A winning offer latches its source number and priority and raises `irq_out` on the next cycle; any source it displaces is returned on `rej_*` in that same cycle; the line is high exactly while a nonzero source is pending.
- R4: Set-IPI-priority (op code 2, value in bits 7:0) stores the value; only if it is below the current priority does the IPI check run: it does nothing when the pending interrupt's priority is less than or equal to the value, otherwise it rejects any pending source and presents source 2 at that priority.
- R5: Accept (op code 0) returns on `acc_data` the word {current priority in bits 31:24, pending source in bits 23:0} with `acc_valid`, lowers the line, clears the source and makes the pending priority the new current priority.
- R6: Set-current-priority (op code 1, value in bits 7:0) to a value below the old one clears a pending interrupt whose priority is greater than or equal to the new value, lowers the line and rejects that source.
- R7: Set-current-priority to an equal or higher value with nothing pending pulses `resend_req`, first presenting the IPI if the IPI priority is below the new current priority.
- R8: End-of-interrupt (op code 3) sets the current priority from bits 31:24, pulses `eoi_valid` with bits 23:0, and, when nothing is pending, performs the same resend as R7.
- R9: A register operation and an offer in the same cycle: only the operation is processed and the offer is bounced on `off_rej_*`; every strobe and `acc_*` appears the cycle after its cause, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offer_valid | input | 1 | Source layer offers an interrupt |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| op_valid | input | 1 | Register operation request |
| op_code | input | 2 | 0 accept, 1 set current priority, 2 set IPI priority, 3 end-of-interrupt |
| op_data | input | 32 | Operation operand |
| irq_out | output | 1 | Interrupt line to the processor |
| acc_valid | output | 1 | Accept result valid |
| acc_data | output | 32 | Accepted state word |
| rej_valid | output | 1 | Pending source displaced or cleared |
| rej_src | output | 24 | Rejected source number |
| off_rej_valid | output | 1 | Offer bounced |
| off_rej_src | output | 24 | Bounced offer's source number |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_src | output | 24 | End-of-interrupt source number |
| resend_req | output | 1 | Ask the source layer to re-offer held interrupts |

## Verification
A nested sweep sets the current priority, the pending priority and the offered priority over every value from 0 to 7. This exercises the strictly-below rule against the current priority and the less-than-or-equal rule against a pending interrupt. It also separates offers that win, offers that displace and offers that bounce, including the ties. A long pseudo-random stream then mixes all four operations, zero and nonzero source numbers, priority 0xff and simultaneous offer/operation cycles. Each cycle is compared with a behavioural model written from the requirements. Directed steps cover the reset state and an IPI that loses to, displaces or is masked against a pending interrupt.

// File: rtl/icp_pkg.sv
package icp_pkg;
  typedef enum logic [1:0] {
    OP_ACCEPT  = 2'd0,
    OP_SET_CUR = 2'd1,
    OP_SET_IPI = 2'd2,
    OP_EOI     = 2'd3
  } icp_op_e;
endpackage

// File: rtl/icp_prio_cmp.sv
// Decides whether a candidate interrupt may be presented: it must beat the
// current priority and must be strictly more favoured than any pending one.
module icp_prio_cmp #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              wins
);
  always_comb begin
    wins = (cand_prio < cur_prio) && !(pend_valid && (pend_prio <= cand_prio));
  end
endmodule

// File: rtl/icp_strobe.sv
// One-cycle registered strobe with a payload held under a clock enable.
module icp_strobe #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= set_i;
      if (set_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/irq_pres_ctrl.sv
module irq_pres_ctrl #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    offer_valid,
  input  logic [SRC_W-1:0]        offer_src,
  input  logic [PRIO_W-1:0]       offer_prio,
  input  logic                    op_valid,
  input  logic [1:0]              op_code,
  input  logic [PRIO_W+SRC_W-1:0] op_data,
  output logic                    irq_out,
  output logic                    acc_valid,
  output logic [PRIO_W+SRC_W-1:0] acc_data,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    off_rej_valid,
  output logic [SRC_W-1:0]        off_rej_src,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    resend_req
);
  import icp_pkg::*;

  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  // state
  logic [PRIO_W-1:0] cppr_q, cppr_d;
  logic [SRC_W-1:0]  xisr_q, xisr_d;
  logic [PRIO_W-1:0] pprio_q, pprio_d;
  logic [PRIO_W-1:0] mfrr_q, mfrr_d;
  logic              irq_q, irq_d;
  logic              resend_q, resend_d;

  // strobe requests
  logic rej_set, offrej_set, eoi_set, acc_set;

  // decode
  icp_op_e           op;
  logic              pend, offer_live;
  logic [PRIO_W-1:0] op_lo, op_hi;
  logic [PRIO_W-1:0] ipi_cand, ipi_cur;
  logic              ipi_win, offer_win;

  always_comb begin
    op         = icp_op_e'(op_code);
    pend       = (xisr_q != '0);
    offer_live = offer_valid && (offer_src != '0);
    op_lo      = op_data[PRIO_W-1:0];
    op_hi      = op_data[WORD_W-1 -: PRIO_W];
    ipi_cand   = (op == OP_SET_IPI) ? op_lo : mfrr_q;
    case (op)
      OP_SET_IPI: ipi_cur = cppr_q;
      OP_EOI:     ipi_cur = op_hi;
      default:    ipi_cur = op_lo;
    endcase
  end

  icp_prio_cmp #(.PRIO_W(PRIO_W)) u_ipi_cmp (
    .cand_prio (ipi_cand),
    .cur_prio  (ipi_cur),
    .pend_valid(pend),
    .pend_prio (pprio_q),
    .wins      (ipi_win)
  );

  icp_prio_cmp #(.PRIO_W(PRIO_W)) u_offer_cmp (
    .cand_prio (offer_prio),
    .cur_prio  (cppr_q),
    .pend_valid(pend),
    .pend_prio (pprio_q),
    .wins      (offer_win)
  );

  // next state
  always_comb begin
    cppr_d     = cppr_q;
    xisr_d     = xisr_q;
    pprio_d    = pprio_q;
    mfrr_d     = mfrr_q;
    irq_d      = irq_q;
    resend_d   = 1'b0;
    rej_set    = 1'b0;
    offrej_set = 1'b0;
    eoi_set    = 1'b0;
    acc_set    = 1'b0;
    if (op_valid) begin
      offrej_set = offer_live;
      case (op)
        OP_ACCEPT: begin
          acc_set = 1'b1;
          irq_d   = 1'b0;
          xisr_d  = '0;
          cppr_d  = pprio_q;
        end
        OP_SET_CUR: begin
          cppr_d = op_lo;
          if (op_lo < cppr_q) begin
            if (pend && (op_lo <= pprio_q)) begin
              rej_set = 1'b1;
              xisr_d  = '0;
              irq_d   = 1'b0;
            end
          end else if (!pend) begin
            resend_d = 1'b1;
            if (ipi_win) begin
              xisr_d  = IPI_NUM;
              pprio_d = ipi_cand;
              irq_d   = 1'b1;
            end
          end
        end
        OP_SET_IPI: begin
          mfrr_d = op_lo;
          if (ipi_win) begin
            rej_set = pend;
            xisr_d  = IPI_NUM;
            pprio_d = ipi_cand;
            irq_d   = 1'b1;
          end
        end
        default: begin
          cppr_d  = op_hi;
          eoi_set = 1'b1;
          if (!pend) begin
            resend_d = 1'b1;
            if (ipi_win) begin
              xisr_d  = IPI_NUM;
              pprio_d = ipi_cand;
              irq_d   = 1'b1;
            end
          end
        end
      endcase
    end else if (offer_live) begin
      if (offer_win) begin
        rej_set = pend;
        xisr_d  = offer_src;
        pprio_d = offer_prio;
        irq_d   = 1'b1;
      end else begin
        offrej_set = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q   <= '0;
      xisr_q   <= '0;
      pprio_q  <= '0;
      mfrr_q   <= '1;
      irq_q    <= 1'b0;
      resend_q <= 1'b0;
    end else begin
      cppr_q   <= cppr_d;
      xisr_q   <= xisr_d;
      pprio_q  <= pprio_d;
      mfrr_q   <= mfrr_d;
      irq_q    <= irq_d;
      resend_q <= resend_d;
    end
  end

  icp_strobe #(.W(SRC_W)) u_rej (
    .clk(clk), .rst_n(rst_n), .set_i(rej_set), .data_i(xisr_q),
    .valid_o(rej_valid), .data_o(rej_src)
  );

  icp_strobe #(.W(SRC_W)) u_offrej (
    .clk(clk), .rst_n(rst_n), .set_i(offrej_set), .data_i(offer_src),
    .valid_o(off_rej_valid), .data_o(off_rej_src)
  );

  icp_strobe #(.W(SRC_W)) u_eoi (
    .clk(clk), .rst_n(rst_n), .set_i(eoi_set), .data_i(op_data[SRC_W-1:0]),
    .valid_o(eoi_valid), .data_o(eoi_src)
  );

  icp_strobe #(.W(WORD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .set_i(acc_set), .data_i({cppr_q, xisr_q}),
    .valid_o(acc_valid), .data_o(acc_data)
  );

  assign irq_out    = irq_q;
  assign resend_req = resend_q;
endmodule

// File: rtl/irq_pres_ctrl_chk.sv
module irq_pres_ctrl_chk #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    offer_valid,
  input logic [SRC_W-1:0]        offer_src,
  input logic                    op_valid,
  input logic [1:0]              op_code,
  input logic [PRIO_W+SRC_W-1:0] op_data,
  input logic                    irq_out,
  input logic                    acc_valid,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    off_rej_valid,
  input logic [SRC_W-1:0]        off_rej_src,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src,
  input logic [SRC_W-1:0]        xisr_q,
  input logic [PRIO_W-1:0]       mfrr_q
);
  // R3: line high exactly while a source is pending
  a_r3_line_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (xisr_q != '0));

  // R3: a rejected source is never the empty number
  a_r3_reject_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_src != '0));

  // R5: accept lowers the line and empties the source field
  a_r5_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd0) |=> (!irq_out && xisr_q == '0 && acc_valid));

  // R4: IPI priority write is stored
  a_r4_ipi_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd2) |=> (mfrr_q == $past(op_data[PRIO_W-1:0])));

  // R8: end-of-interrupt forwards the low source field
  a_r8_eoi_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd3) |=> (eoi_valid && eoi_src == $past(op_data[SRC_W-1:0])));

  // R9: an offer colliding with an operation is bounced
  a_r9_offer_bounced: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && offer_valid && offer_src != '0) |=>
      (off_rej_valid && off_rej_src == $past(offer_src)));
endmodule

bind irq_pres_ctrl irq_pres_ctrl_chk #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_src(offer_src),
  .op_valid(op_valid), .op_code(op_code), .op_data(op_data), .irq_out(irq_out),
  .acc_valid(acc_valid), .rej_valid(rej_valid), .rej_src(rej_src),
  .off_rej_valid(off_rej_valid), .off_rej_src(off_rej_src),
  .eoi_valid(eoi_valid), .eoi_src(eoi_src), .xisr_q(xisr_q), .mfrr_q(mfrr_q)
);

// File: tb/sim_irq_pres_ctrl.sv
`timescale 1ns/1ps
module sim_irq_pres_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        offer_valid;
  logic [23:0] offer_src;
  logic [7:0]  offer_prio;
  logic        op_valid;
  logic [1:0]  op_code;
  logic [31:0] op_data;
  logic        irq_out, acc_valid, rej_valid, off_rej_valid, eoi_valid, resend_req;
  logic [31:0] acc_data;
  logic [23:0] rej_src, off_rej_src, eoi_src;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  irq_pres_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_src(offer_src),
    .offer_prio(offer_prio), .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .irq_out(irq_out), .acc_valid(acc_valid), .acc_data(acc_data),
    .rej_valid(rej_valid), .rej_src(rej_src), .off_rej_valid(off_rej_valid),
    .off_rej_src(off_rej_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .resend_req(resend_req)
  );

  // reference model state
  logic [7:0]  m_cppr, m_pp, m_mfrr;
  logic [23:0] m_xisr;
  logic        m_irq;

  task automatic cmp(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ipi_present(input logic [7:0] p, inout logic e_rej, inout logic [23:0] e_rej_src);
    if (m_xisr != 0) begin
      e_rej = 1; e_rej_src = m_xisr;
    end
    m_xisr = 24'd2; m_pp = p; m_irq = 1;
  endtask

  task automatic step(input logic ov, input logic [23:0] os, input logic [7:0] opr,
                      input logic opv, input logic [1:0] oc, input logic [31:0] od);
    logic e_acc = 0, e_rej = 0, e_orej = 0, e_eoi = 0, e_rs = 0;
    logic [31:0] e_acc_d = 0;
    logic [23:0] e_rej_src = 0, e_orej_src = 0, e_eoi_src = 0;
    logic live;
    logic [7:0] nc;
    offer_valid = ov; offer_src = os; offer_prio = opr;
    op_valid = opv; op_code = oc; op_data = od;
    live = ov && (os != 0);
    if (opv) begin
      if (live) begin e_orej = 1; e_orej_src = os; end   // R9
      case (oc)
        2'd0: begin                                        // R5
          e_acc = 1; e_acc_d = {m_cppr, m_xisr};
          m_xisr = 0; m_cppr = m_pp; m_irq = 0;
        end
        2'd1: begin
          nc = od[7:0];
          if (nc < m_cppr) begin                           // R6
            if (m_xisr != 0 && nc <= m_pp) begin
              e_rej = 1; e_rej_src = m_xisr; m_xisr = 0; m_irq = 0;
            end
            m_cppr = nc;
          end else begin                                   // R7
            m_cppr = nc;
            if (m_xisr == 0) begin
              e_rs = 1;
              if (m_mfrr < m_cppr) ipi_present(m_mfrr, e_rej, e_rej_src);
            end
          end
        end
        2'd2: begin                                        // R4
          m_mfrr = od[7:0];
          if (m_mfrr < m_cppr && !(m_xisr != 0 && m_pp <= m_mfrr))
            ipi_present(m_mfrr, e_rej, e_rej_src);
        end
        default: begin                                     // R8
          m_cppr = od[31:24];
          e_eoi = 1; e_eoi_src = od[23:0];
          if (m_xisr == 0) begin
            e_rs = 1;
            if (m_mfrr < m_cppr) ipi_present(m_mfrr, e_rej, e_rej_src);
          end
        end
      endcase
    end else if (live) begin
      if (opr >= m_cppr || (m_xisr != 0 && m_pp <= opr)) begin   // R2
        e_orej = 1; e_orej_src = os;
      end else begin                                              // R3
        if (m_xisr != 0) begin e_rej = 1; e_rej_src = m_xisr; end
        m_xisr = os; m_pp = opr; m_irq = 1;
      end
    end
    @(negedge clk);
    cmp("R3", "irq_out", {31'd0, irq_out}, {31'd0, m_irq});
    cmp("R3", "rej_valid", {31'd0, rej_valid}, {31'd0, e_rej});
    if (e_rej) cmp("R3", "rej_src", {8'd0, rej_src}, {8'd0, e_rej_src});
    cmp("R2", "off_rej_valid", {31'd0, off_rej_valid}, {31'd0, e_orej});
    if (e_orej) cmp("R2", "off_rej_src", {8'd0, off_rej_src}, {8'd0, e_orej_src});
    cmp("R5", "acc_valid", {31'd0, acc_valid}, {31'd0, e_acc});
    if (e_acc) cmp("R5", "acc_data", acc_data, e_acc_d);
    cmp("R8", "eoi_valid", {31'd0, eoi_valid}, {31'd0, e_eoi});
    if (e_eoi) cmp("R8", "eoi_src", {8'd0, eoi_src}, {8'd0, e_eoi_src});
    cmp("R7", "resend_req", {31'd0, resend_req}, {31'd0, e_rs});
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 0;
    offer_valid = 0; offer_src = 0; offer_prio = 0;
    op_valid = 0; op_code = 0; op_data = 0;
    m_cppr = 0; m_pp = 0; m_mfrr = 8'hff; m_xisr = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1", "irq_out", {31'd0, irq_out}, 32'd0);
    cmp("R1", "strobes", {26'd0, acc_valid, rej_valid, off_rej_valid, eoi_valid, resend_req, 1'b0}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    step(0, 0, 0, 1, 2'd0, 0);            // R1: state word reads zero
    step(0, 0, 0, 1, 2'd1, 32'hff);       // R1: IPI prio 0xff, no IPI presented
    cmp("R1", "no IPI after reset", {31'd0, irq_out}, 32'd0);

    // R4 directed: pending at 3, IPI at 5 loses; IPI at 1 displaces
    step(1, 24'h40, 8'd3, 0, 0, 0);
    step(0, 0, 0, 1, 2'd2, 32'd5);
    step(0, 0, 0, 1, 2'd2, 32'd1);
    step(0, 0, 0, 1, 2'd0, 0);
    step(0, 0, 0, 1, 2'd3, 32'hff00_0002);
    step(0, 0, 0, 1, 2'd2, 32'hff);
    // R2: zero source ignored
    step(1, 24'h0, 8'd0, 0, 0, 0);
    cmp("R2", "zero source ignored", {31'd0, irq_out}, {31'd0, m_irq});

    // near-exhaustive sweep: current, pending and offered priority 0..7
    for (int cp = 0; cp < 8; cp++)
      for (int pp = 0; pp < 8; pp++)
        for (int op = 0; op < 8; op++) begin
          step(0, 0, 0, 1, 2'd0, 0);
          step(0, 0, 0, 1, 2'd1, 32'hff);
          step(1, 24'h100, pp[7:0], 0, 0, 0);
          step(0, 0, 0, 1, 2'd1, {24'd0, cp[7:0]});   // R6
          step(1, 24'h200, op[7:0], 0, 0, 0);         // R2 / R3
          step(1, 24'h300, op[7:0], 1, 2'd2, {24'd0, pp[7:0]}); // R4 / R9
        end

    // pseudo-random mixed stream
    lfsr = 32'h1234_5678;
    for (int i = 0; i < 20000; i++) begin
      logic [7:0] pr;
      logic [7:0] pr2;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      pr  = (lfsr[3:0] == 4'hf) ? 8'hff : {5'd0, lfsr[6:4]};
      pr2 = (lfsr[22:20] == 3'd7) ? 8'hff : {5'd0, lfsr[26:24]};
      step(lfsr[7], {21'd0, lfsr[10:8]}, pr, lfsr[11] & lfsr[12], lfsr[14:13],
           {pr2, 21'd0, lfsr[17:15]});
    end

    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule